// File: doc/BRIEF.md
# PLL Control Register Interlock

This block holds the software-visible control state of a clock generator's phase-locked loop: a loop-enable bit, a bit that asks for the oscillator output to become the base clock, a 12-bit multiplier field and an 8-bit divider field. Software writes all four in one bus write. The block checks each write against the current state before storing it, so that an illegal pairing of the two bits can never take effect.

Three outputs go to the rest of the clock generator. The first is an effective loop enable. The second is an effective request for the oscillator clock, sent to the clock switch. The third is the multiplier with zero replaced by one. A divider of zero counts as a forced shutdown: the loop is reported as disabled and the crystal clock stays selected. The read port shows the stored state after filtering, so software can tell whether its write was accepted.

Top module: `pll_ctl_guard`

## Requirements
- R1: After reset the stored enable bit is 0, the stored select bit is 0, the stored multiplier is 1 and the stored divider is 0.
- R2: A write that sets the select bit while the stored enable bit is 0 leaves the select bit at 0.
- R3: A write that clears the enable bit while the stored select bit is 1 leaves the enable bit at 1.
- R4: If one write would change both the enable bit and the select bit, neither bit changes, and the multiplier and divider fields still take the written values.
- R5: A write that sets the select bit with a written divider of 0 leaves the select bit at 0.
- R6: A write with divider 0 clears the stored select bit in that same write, so the oscillator request is low from the next cycle on.
- R7: The effective loop enable is high exactly when the stored enable bit is 1 and the stored divider is nonzero.
- R8: The effective multiplier equals the stored multiplier, except that a stored value of 0 gives 1.
- R9: The read port returns the stored enable, select, multiplier and divider values after filtering. A single legal change of one bit is applied as written.
- R10: With no write strobe, all stored values and outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_pll_on | input | 1 | Written loop-enable bit |
| wr_vco_sel | input | 1 | Written oscillator-select bit |
| wr_mul | input | 12 | Written multiplier |
| wr_div | input | 8 | Written divider |
| rd_pll_on | output | 1 | Stored loop-enable bit |
| rd_vco_sel | output | 1 | Stored oscillator-select bit |
| rd_mul | output | 12 | Stored multiplier |
| rd_div | output | 8 | Stored divider |
| pll_en_eff | output | 1 | Effective loop enable |
| vco_req | output | 1 | Effective oscillator-clock request to the clock switch |
| mul_eff | output | 12 | Multiplier with 0 replaced by 1 |

## Verification
The hardest cases are the writes that meet a state with the select bit already set. In that state the enable-clear is refused, a divider of zero clears the select, and a write that flips both bits is refused. This state can only be reached by a legal sequence: first enable with a nonzero divider, then select. The bench builds each start state that way, after a fresh reset. From every reachable start state it applies all four bit patterns, with a zero divider and with a nonzero one, and compares the result against an arithmetic model of the rules. A separate sweep writes every multiplier value.

// File: rtl/pll_ctl_guard.sv
module pll_ctl_guard #(
  parameter int MUL_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_pll_on,
  input  logic             wr_vco_sel,
  input  logic [MUL_W-1:0] wr_mul,
  input  logic [DIV_W-1:0] wr_div,
  output logic             rd_pll_on,
  output logic             rd_vco_sel,
  output logic [MUL_W-1:0] rd_mul,
  output logic [DIV_W-1:0] rd_div,
  output logic             pll_en_eff,
  output logic             vco_req,
  output logic [MUL_W-1:0] mul_eff
);

  localparam logic [MUL_W-1:0] MUL_ONE = MUL_W'(1);

  logic             on_q, sel_q;
  logic [MUL_W-1:0] mul_q;
  logic [DIV_W-1:0] div_q;
  logic             on_chg, sel_chg, dual, div_ok, on_nx, sel_nx;

  assign on_chg  = wr_pll_on ^ on_q;
  assign sel_chg = wr_vco_sel ^ sel_q;
  assign dual    = on_chg & sel_chg;
  assign div_ok  = |wr_div;

  // clearing the enable is refused while select is held (sel_q)
  assign on_nx  = (dual | ~on_chg)  ? on_q  : (wr_pll_on | sel_q);
  assign sel_nx = div_ok & ((dual | ~sel_chg) ? sel_q : (wr_vco_sel & on_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      sel_q <= 1'b0;
      mul_q <= MUL_ONE;
      div_q <= '0;
    end else if (wr_en) begin
      on_q  <= on_nx;
      sel_q <= sel_nx;
      mul_q <= wr_mul;
      div_q <= wr_div;
    end
  end

  assign rd_pll_on  = on_q;
  assign rd_vco_sel = sel_q;
  assign rd_mul     = mul_q;
  assign rd_div     = div_q;
  assign pll_en_eff = on_q & (|div_q);
  assign vco_req    = sel_q & (|div_q);
  assign mul_eff    = (mul_q == '0) ? MUL_ONE : mul_q;

endmodule

bind pll_ctl_guard pll_ctl_guard_chk #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pll_on(wr_pll_on),
  .wr_vco_sel(wr_vco_sel), .wr_div(wr_div), .rd_pll_on(rd_pll_on),
  .rd_vco_sel(rd_vco_sel), .rd_mul(rd_mul), .rd_div(rd_div),
  .pll_en_eff(pll_en_eff), .vco_req(vco_req), .mul_eff(mul_eff)
);

module pll_ctl_guard_chk #(
  parameter int MUL_W = 12,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_pll_on,
  input logic             wr_vco_sel,
  input logic [DIV_W-1:0] wr_div,
  input logic             rd_pll_on,
  input logic             rd_vco_sel,
  input logic [MUL_W-1:0] rd_mul,
  input logic [DIV_W-1:0] rd_div,
  input logic             pll_en_eff,
  input logic             vco_req,
  input logic [MUL_W-1:0] mul_eff
);

  p_sel_needs_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vco_sel |-> rd_pll_on);

  p_off_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_vco_sel && !wr_pll_on && wr_vco_sel) |=> rd_pll_on);

  p_no_dual_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_pll_on != rd_pll_on) && (wr_vco_sel != rd_vco_sel))
      |=> (rd_pll_on == $past(rd_pll_on)) && !$rose(rd_vco_sel));

  p_sel_needs_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vco_sel |-> (rd_div != '0));

  p_zero_div_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_div == '0) |=> !vco_req && !rd_vco_sel);

  p_req_implies_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vco_req |-> pll_en_eff);

  p_mul_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mul_eff != '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_pll_on) && $stable(rd_vco_sel) && $stable(rd_mul) && $stable(rd_div));

endmodule

// File: tb/sim_pll_ctl_guard.sv
`timescale 1ns/1ps
module sim_pll_ctl_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_pll_on = 1'b0, wr_vco_sel = 1'b0;
  logic [11:0] wr_mul = '0;
  logic [7:0]  wr_div = '0;
  logic        rd_pll_on, rd_vco_sel, pll_en_eff, vco_req;
  logic [11:0] rd_mul, mul_eff;
  logic [7:0]  rd_div;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_ctl_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pll_on(wr_pll_on),
    .wr_vco_sel(wr_vco_sel), .wr_mul(wr_mul), .wr_div(wr_div),
    .rd_pll_on(rd_pll_on), .rd_vco_sel(rd_vco_sel), .rd_mul(rd_mul),
    .rd_div(rd_div), .pll_en_eff(pll_en_eff), .vco_req(vco_req), .mul_eff(mul_eff)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(bit on, bit sel, int n, int l);
    @(negedge clk);
    wr_en = 1'b1; wr_pll_on = on; wr_vco_sel = sel;
    wr_mul = 12'(n); wr_div = 8'(l);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset values
    chk("R1 on", rd_pll_on, 0);
    chk("R1 sel", rd_vco_sel, 0);
    chk("R1 mul", rd_mul, 1);
    chk("R1 div", rd_div, 0);
    chk("R7 en at reset", pll_en_eff, 0);

    // Sweep start states 00, 10, 11 x write bits x divider zero/nonzero
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < 4; w++) begin
        for (int z = 0; z < 2; z++) begin
          bit on0, sel0, won, wsel, oc, sc, eon, esel;
          int l, n;
          on0 = (s != 0); sel0 = (s == 2);
          won = w[1]; wsel = w[0];
          l = z ? 8'h5A : 0;
          n = 16 * s + 4 * w + z + 7;
          do_reset();
          if (on0)  wr(1'b1, 1'b0, 3, 9);
          if (sel0) wr(1'b1, 1'b1, 3, 9);
          chk("R9 start on", rd_pll_on, on0);
          chk("R9 start sel", rd_vco_sel, sel0);
          oc = (won != on0); sc = (wsel != sel0);
          if (oc && sc) begin eon = on0; esel = sel0; end
          else begin
            eon  = oc ? (won ? 1'b1 : sel0) : on0;
            esel = sc ? (wsel ? on0 : 1'b0) : sel0;
          end
          if (l == 0) esel = 1'b0;
          wr(won, wsel, n, l);
          if (oc && sc) begin
            chk("R4 on kept", rd_pll_on, eon);
            chk("R4 sel kept", rd_vco_sel, esel);
            chk("R4 mul updates", rd_mul, n);
            chk("R4 div updates", rd_div, l);
          end else begin
            if (!on0 && wsel) chk("R2 sel refused", rd_vco_sel, 0);
            if (sel0 && !won) chk("R3 off refused", rd_pll_on, 1);
            if (l == 0 && wsel) chk("R5 sel needs div", rd_vco_sel, 0);
            chk("R9 on", rd_pll_on, eon);
            chk("R9 sel", rd_vco_sel, esel);
            chk("R9 div", rd_div, l);
          end
          if (l == 0) chk("R6 req low", vco_req, 0);
          chk("R7 eff enable", pll_en_eff, (eon && l != 0));
          // R10: idle cycles hold
          repeat (3) @(negedge clk);
          chk("R10 on hold", rd_pll_on, eon);
          chk("R10 sel hold", rd_vco_sel, esel);
          chk("R10 mul hold", rd_mul, n);
        end
      end
    end

    // R8: every multiplier value
    do_reset();
    for (int n = 0; n < 4096; n++) begin
      wr(1'b1, 1'b0, n, 1);
      chk("R9 mul", rd_mul, n);
      chk("R8 mul eff", mul_eff, (n == 0) ? 1 : n);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule